// File: doc/BRIEF.md
# USB Endpoint Buffer Ownership Controller

This block holds the data buffers of one USB endpoint: one set for the IN direction (device to host) and one for the OUT direction (host to device). Each buffer holds up to 64 bytes. A busy bit on each buffer decides who owns it. When the bit is clear, the processor owns the buffer through the CPU port. When it is set, the serial interface engine owns it through the engine port. The processor hands an IN buffer to the engine by writing its byte count. The engine takes an OUT buffer the moment it starts to receive a packet. While the engine holds a buffer, processor accesses to that buffer are dropped without any error.

Each time a buffer passes from the engine back to the processor, the busy bit falls and a per-direction flag is raised, provided its enable is set. A flag stays set until the processor writes a one to clear it. With double buffering enabled, each direction has two buffers. The engine and the processor each step through the two buffers in the same order, so the processor can fill or drain one buffer while the engine streams the other, and packets are consumed in the order they were produced. USB line signalling is handled elsewhere.

Top module: `usb_ep_buf_ctl`

## Requirements
- R1: After reset, every busy bit, byte count, interrupt flag and `irq_o` is 0, `tx_avail_o` is 0, and every buffer pointer selects buffer 0.
- R2: A CPU byte write with `cpu_dir_i` = 0 (IN) or 1 (OUT) stores `cpu_wdata_i` at `cpu_addr_i` of that direction's current CPU buffer when that buffer is not busy. `cpu_rdata_o` returns that byte combinationally.
- R3: While the current CPU buffer of the selected direction is busy, CPU byte writes leave its contents unchanged and `cpu_rdata_o` reads 0.
- R4: An IN count write to a non-busy CPU buffer sets its busy bit on the next cycle and stores the count, clamped to 64. In double-buffer mode it also moves the CPU pointer to the other buffer.
- R5: An IN count write to a busy buffer is ignored: the busy bit, the stored count and the pointer are all unchanged.
- R6: While the engine's IN buffer is busy, `tx_avail_o` is 1, `tx_cnt_o` gives its count and `tx_data_o` gives the byte at the read position. The read position starts at address 0 and advances by one on each `tx_next_i`, but never beyond the count.
- R7: `tx_done_i` clears the busy bit of the engine's IN buffer only when all counted bytes have been read. An earlier `tx_done_i` is ignored. When the bit clears, the engine IN pointer moves to the other buffer (double-buffer mode).
- R8: `rx_start_i` sets the busy bit of the engine's OUT buffer and restarts its write position at 0, including when a reception is already in progress.
- R9: Each `rx_valid_i` byte is written at the next sequential address of the receiving buffer. Bytes beyond 64 are dropped.
- R10: `rx_end_i` on a busy OUT buffer clears its busy bit, loads its count with the number of bytes kept (at most 64) and moves the engine OUT pointer to the other buffer (double-buffer mode).
- R11: An OUT count write to a non-busy buffer releases it: it moves the CPU OUT pointer (double-buffer mode) and never changes any stored count.
- R12: Each busy 1-to-0 transition sets the flag of its direction (bit 0 IN, bit 1 OUT) when the matching `irq_en_i` bit is 1. When that bit is 0, the flag is not set.
- R13: A 1 on an `irq_clr_i` bit clears that flag, except that a new transition in the same cycle wins. `irq_o` is the OR of all flags whose enable bit is set.
- R14: In double-buffer mode, the processor can access one buffer of a direction while the engine owns the other. Buffers reach the processor in the order the engine finished them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_dir_i | input | 1 | CPU direction select: 0 IN, 1 OUT |
| cpu_we_i | input | 1 | CPU byte write strobe |
| cpu_addr_i | input | 6 | CPU byte address |
| cpu_wdata_i | input | 8 | CPU write byte |
| cpu_rdata_o | output | 8 | CPU read byte, 0 while busy |
| cpu_cnt_we_i | input | 1 | CPU byte-count write (IN: hand-off, OUT: release) |
| cpu_cnt_wdata_i | input | 7 | Byte count written for IN |
| cpu_cnt_o | output | 7 | Byte count of the current CPU buffer |
| cpu_busy_o | output | 2 | Busy bit of the current CPU buffer, bit 0 IN, bit 1 OUT |
| irq_en_i | input | 2 | Interrupt enables per direction |
| irq_clr_i | input | 2 | Write-one-to-clear strobes per flag |
| irq_flag_o | output | 2 | Interrupt flags per direction |
| irq_o | output | 1 | Interrupt request |
| rx_start_i | input | 1 | Engine begins an OUT packet |
| rx_valid_i | input | 1 | Engine received byte valid |
| rx_data_i | input | 8 | Engine received byte |
| rx_end_i | input | 1 | Engine ends the OUT packet |
| tx_avail_o | output | 1 | IN data ready for the engine |
| tx_cnt_o | output | 7 | Byte count of the engine's IN buffer |
| tx_data_o | output | 8 | IN byte at the engine read position |
| tx_next_i | input | 1 | Engine takes the current IN byte |
| tx_done_i | input | 1 | Engine reports the IN transfer complete |

## Verification
A pointer that is out of step shows up on the very next access. It either returns bytes from the wrong packet on `tx_data_o` or `cpu_rdata_o`, or raises `cpu_busy_o` against a buffer the processor should own. A busy bit that fails to set or clear shows within one cycle on `tx_avail_o` or `cpu_busy_o`, and in the contents of a buffer that was written while it should have been locked. A wrong stored count appears at once on `tx_cnt_o` or `cpu_cnt_o`. It also surfaces one packet later as a refused completion, or as stray or missing stream bytes.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;
  typedef enum logic {
    EP_DIR_IN  = 1'b0,
    EP_DIR_OUT = 1'b1
  } ep_dir_e;
endpackage

// File: rtl/ep_buf_ram.sv
module ep_buf_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/ep_irq.sv
module ep_irq #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] fall_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o,
  output logic         irq_o
);
  logic [N-1:0] flag_q;

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (fall_i & en_i) | (flag_q & ~clr_i);
  end

  assign flag_o = flag_q;
  assign irq_o  = |(flag_q & en_i);

  for (genvar d = 0; d < N; d++) begin : g_chk
    assert_flag_cause_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_q[d]) |-> $past(fall_i[d] && en_i[d]));
    assert_flag_clear_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[d] && !fall_i[d]) |=> !flag_q[d]);
  end
endmodule

// File: rtl/ep_in_ctl.sv
module ep_in_ctl #(
  parameter int DW         = 8,
  parameter int DEPTH      = 64,
  parameter bit DOUBLE_BUF = 1'b1,
  localparam int AW        = $clog2(DEPTH),
  localparam int CW        = $clog2(DEPTH + 1),
  localparam int NBUF      = DOUBLE_BUF ? 2 : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cpu_we_i,
  input  logic [AW-1:0] cpu_addr_i,
  input  logic [DW-1:0] cpu_wdata_i,
  output logic [DW-1:0] cpu_rdata_o,
  input  logic          cpu_cnt_we_i,
  input  logic [CW-1:0] cpu_cnt_wdata_i,
  output logic [CW-1:0] cpu_cnt_o,
  output logic          cpu_busy_o,
  output logic          tx_avail_o,
  output logic [CW-1:0] tx_cnt_o,
  output logic [DW-1:0] tx_data_o,
  input  logic          tx_next_i,
  input  logic          tx_done_i,
  output logic          busy_fall_o
);
  localparam logic STEP = DOUBLE_BUF;

  logic [1:0]          busy_q;
  logic [1:0][CW-1:0]  cnt_q;
  logic                cpu_ptr_q, eng_ptr_q;
  logic [CW-1:0]       rptr_q;
  logic [1:0][DW-1:0]  rd;
  logic [CW-1:0]       cnt_clamp;
  logic                eng_busy, cnt_load, tx_fin, tx_adv;

  for (genvar b = 0; b < 2; b++) begin : g_buf
    if (b < NBUF) begin : g_mem
      ep_buf_ram #(.DW(DW), .DEPTH(DEPTH)) i_ram (
        .clk_i   (clk_i),
        .we_i    (cpu_we_i && !busy_q[b] && (cpu_ptr_q == 1'(b))),
        .waddr_i (cpu_addr_i),
        .wdata_i (cpu_wdata_i),
        .raddr_i (busy_q[b] ? rptr_q[AW-1:0] : cpu_addr_i),
        .rdata_o (rd[b])
      );
    end else begin : g_none
      assign rd[b] = '0;
    end
  end

  assign cpu_busy_o  = busy_q[cpu_ptr_q];
  assign cpu_rdata_o = cpu_busy_o ? '0 : rd[cpu_ptr_q];
  assign cpu_cnt_o   = cnt_q[cpu_ptr_q];
  assign eng_busy    = busy_q[eng_ptr_q];
  assign tx_avail_o  = eng_busy;
  assign tx_cnt_o    = cnt_q[eng_ptr_q];
  assign tx_data_o   = rd[eng_ptr_q];

  assign cnt_clamp   = (cpu_cnt_wdata_i > CW'(DEPTH)) ? CW'(DEPTH) : cpu_cnt_wdata_i;
  assign cnt_load    = cpu_cnt_we_i && !cpu_busy_o;
  assign tx_fin      = tx_done_i && eng_busy && (rptr_q == tx_cnt_o);
  assign tx_adv      = tx_next_i && eng_busy && (rptr_q < tx_cnt_o);
  assign busy_fall_o = tx_fin;

  // cpu side only touches an idle buffer, engine side only a busy one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= '0;
      cnt_q     <= '0;
      cpu_ptr_q <= 1'b0;
      eng_ptr_q <= 1'b0;
      rptr_q    <= '0;
    end else begin
      if (cnt_load) begin
        busy_q[cpu_ptr_q] <= 1'b1;
        cnt_q[cpu_ptr_q]  <= cnt_clamp;
        cpu_ptr_q         <= cpu_ptr_q ^ STEP;
      end
      if (tx_fin) begin
        busy_q[eng_ptr_q] <= 1'b0;
        eng_ptr_q         <= eng_ptr_q ^ STEP;
        rptr_q            <= '0;
      end else if (tx_adv) begin
        rptr_q <= rptr_q + CW'(1);
      end
    end
  end

  assert_cnt_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q[0] <= CW'(DEPTH)) && (cnt_q[1] <= CW'(DEPTH)));
  assert_busy_cnt_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_cnt_we_i && cpu_busy_o) |=> ($stable(cnt_q) && $stable(cpu_ptr_q)));
  assert_rptr_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_avail_o |-> (rptr_q <= tx_cnt_o));
  assert_early_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_done_i && tx_avail_o && (rptr_q != tx_cnt_o)) |=> $stable(eng_ptr_q));
endmodule

// File: rtl/ep_out_ctl.sv
module ep_out_ctl #(
  parameter int DW         = 8,
  parameter int DEPTH      = 64,
  parameter bit DOUBLE_BUF = 1'b1,
  localparam int AW        = $clog2(DEPTH),
  localparam int CW        = $clog2(DEPTH + 1),
  localparam int NBUF      = DOUBLE_BUF ? 2 : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cpu_we_i,
  input  logic [AW-1:0] cpu_addr_i,
  input  logic [DW-1:0] cpu_wdata_i,
  output logic [DW-1:0] cpu_rdata_o,
  input  logic          cpu_cnt_we_i,
  output logic [CW-1:0] cpu_cnt_o,
  output logic          cpu_busy_o,
  input  logic          rx_start_i,
  input  logic          rx_valid_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          rx_end_i,
  output logic          busy_fall_o
);
  localparam logic STEP = DOUBLE_BUF;

  logic [1:0]          busy_q;
  logic [1:0][CW-1:0]  cnt_q;
  logic                cpu_ptr_q, eng_ptr_q;
  logic [CW-1:0]       wptr_q;
  logic [1:0][DW-1:0]  rd;
  logic                eng_busy, rx_wr, rx_fin, release_buf;

  assign eng_busy = busy_q[eng_ptr_q];
  assign rx_wr    = rx_valid_i && eng_busy && (wptr_q < CW'(DEPTH));

  for (genvar b = 0; b < 2; b++) begin : g_buf
    if (b < NBUF) begin : g_mem
      logic we_eng, we_cpu;
      assign we_eng = busy_q[b] && rx_wr && (eng_ptr_q == 1'(b));
      assign we_cpu = !busy_q[b] && cpu_we_i && (cpu_ptr_q == 1'(b));
      ep_buf_ram #(.DW(DW), .DEPTH(DEPTH)) i_ram (
        .clk_i   (clk_i),
        .we_i    (we_eng || we_cpu),
        .waddr_i (busy_q[b] ? wptr_q[AW-1:0] : cpu_addr_i),
        .wdata_i (busy_q[b] ? rx_data_i : cpu_wdata_i),
        .raddr_i (cpu_addr_i),
        .rdata_o (rd[b])
      );
    end else begin : g_none
      assign rd[b] = '0;
    end
  end

  assign cpu_busy_o  = busy_q[cpu_ptr_q];
  assign cpu_rdata_o = cpu_busy_o ? '0 : rd[cpu_ptr_q];
  assign cpu_cnt_o   = cnt_q[cpu_ptr_q];
  assign rx_fin      = rx_end_i && eng_busy && !rx_start_i;
  assign release_buf = cpu_cnt_we_i && !cpu_busy_o;
  assign busy_fall_o = rx_fin;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= '0;
      cnt_q     <= '0;
      cpu_ptr_q <= 1'b0;
      eng_ptr_q <= 1'b0;
      wptr_q    <= '0;
    end else begin
      if (release_buf) cpu_ptr_q <= cpu_ptr_q ^ STEP;
      if (rx_start_i) begin
        busy_q[eng_ptr_q] <= 1'b1;
        wptr_q            <= '0;
      end else if (rx_fin) begin
        busy_q[eng_ptr_q] <= 1'b0;
        cnt_q[eng_ptr_q]  <= wptr_q;
        eng_ptr_q         <= eng_ptr_q ^ STEP;
        wptr_q            <= '0;
      end else if (rx_wr) begin
        wptr_q <= wptr_q + CW'(1);
      end
    end
  end

  assert_rx_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_start_i |=> eng_busy);
  assert_wptr_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wptr_q <= CW'(DEPTH));
  assert_release_cnt_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_cnt_we_i && !rx_end_i) |=> $stable(cnt_q));
endmodule

// File: rtl/usb_ep_buf_ctl.sv
module usb_ep_buf_ctl
  import usb_ep_pkg::*;
#(
  parameter int DW         = 8,
  parameter int DEPTH      = 64,
  parameter bit DOUBLE_BUF = 1'b1,
  localparam int AW        = $clog2(DEPTH),
  localparam int CW        = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cpu_dir_i,
  input  logic          cpu_we_i,
  input  logic [AW-1:0] cpu_addr_i,
  input  logic [DW-1:0] cpu_wdata_i,
  output logic [DW-1:0] cpu_rdata_o,
  input  logic          cpu_cnt_we_i,
  input  logic [CW-1:0] cpu_cnt_wdata_i,
  output logic [CW-1:0] cpu_cnt_o,
  output logic [1:0]    cpu_busy_o,
  input  logic [1:0]    irq_en_i,
  input  logic [1:0]    irq_clr_i,
  output logic [1:0]    irq_flag_o,
  output logic          irq_o,
  input  logic          rx_start_i,
  input  logic          rx_valid_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          rx_end_i,
  output logic          tx_avail_o,
  output logic [CW-1:0] tx_cnt_o,
  output logic [DW-1:0] tx_data_o,
  input  logic          tx_next_i,
  input  logic          tx_done_i
);
  logic          sel_out;
  logic [DW-1:0] in_rdata, out_rdata;
  logic [CW-1:0] in_cnt, out_cnt;
  logic          in_busy, out_busy, in_fall, out_fall;

  assign sel_out = (ep_dir_e'(cpu_dir_i) == EP_DIR_OUT);

  ep_in_ctl #(.DW(DW), .DEPTH(DEPTH), .DOUBLE_BUF(DOUBLE_BUF)) i_in (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .cpu_we_i        (cpu_we_i && !sel_out),
    .cpu_addr_i      (cpu_addr_i),
    .cpu_wdata_i     (cpu_wdata_i),
    .cpu_rdata_o     (in_rdata),
    .cpu_cnt_we_i    (cpu_cnt_we_i && !sel_out),
    .cpu_cnt_wdata_i (cpu_cnt_wdata_i),
    .cpu_cnt_o       (in_cnt),
    .cpu_busy_o      (in_busy),
    .tx_avail_o      (tx_avail_o),
    .tx_cnt_o        (tx_cnt_o),
    .tx_data_o       (tx_data_o),
    .tx_next_i       (tx_next_i),
    .tx_done_i       (tx_done_i),
    .busy_fall_o     (in_fall)
  );

  ep_out_ctl #(.DW(DW), .DEPTH(DEPTH), .DOUBLE_BUF(DOUBLE_BUF)) i_out (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cpu_we_i     (cpu_we_i && sel_out),
    .cpu_addr_i   (cpu_addr_i),
    .cpu_wdata_i  (cpu_wdata_i),
    .cpu_rdata_o  (out_rdata),
    .cpu_cnt_we_i (cpu_cnt_we_i && sel_out),
    .cpu_cnt_o    (out_cnt),
    .cpu_busy_o   (out_busy),
    .rx_start_i   (rx_start_i),
    .rx_valid_i   (rx_valid_i),
    .rx_data_i    (rx_data_i),
    .rx_end_i     (rx_end_i),
    .busy_fall_o  (out_fall)
  );

  ep_irq #(.N(2)) i_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fall_i ({out_fall, in_fall}),
    .en_i   (irq_en_i),
    .clr_i  (irq_clr_i),
    .flag_o (irq_flag_o),
    .irq_o  (irq_o)
  );

  assign cpu_rdata_o = sel_out ? out_rdata : in_rdata;
  assign cpu_cnt_o   = sel_out ? out_cnt : in_cnt;
  assign cpu_busy_o  = {out_busy, in_busy};

  assert_tx_count_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_avail_o |-> (tx_cnt_o <= CW'(DEPTH)));
endmodule

// File: tb/test_usb_ep_buf_ctl.sv
module test_usb_ep_buf_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int DEPTH = 64;
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_dir = 1'b0, cpu_we = 1'b0, cnt_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [CW-1:0] cnt_wdata = '0;
  logic [1:0]    irq_en = '0, irq_clr = '0;
  logic          rx_start = 1'b0, rx_valid = 1'b0, rx_end = 1'b0;
  logic [DW-1:0] rx_data = '0;
  logic          tx_next = 1'b0, tx_done = 1'b0;
  logic [DW-1:0] cpu_rdata, tx_data;
  logic [CW-1:0] cpu_cnt, tx_cnt;
  logic [1:0]    cpu_busy, irq_flag;
  logic          irq, tx_avail;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [DW-1:0] tx_q[$];
  logic [DW-1:0] out_q[$];
  logic rd_chk = 1'b0;
  logic tx_skip = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_ep_buf_ctl i_usb_ep_buf_ctl (
    .clk_i (clk), .rst_ni (rst_n),
    .cpu_dir_i (cpu_dir), .cpu_we_i (cpu_we), .cpu_addr_i (cpu_addr),
    .cpu_wdata_i (cpu_wdata), .cpu_rdata_o (cpu_rdata),
    .cpu_cnt_we_i (cnt_we), .cpu_cnt_wdata_i (cnt_wdata), .cpu_cnt_o (cpu_cnt),
    .cpu_busy_o (cpu_busy), .irq_en_i (irq_en), .irq_clr_i (irq_clr),
    .irq_flag_o (irq_flag), .irq_o (irq),
    .rx_start_i (rx_start), .rx_valid_i (rx_valid), .rx_data_i (rx_data), .rx_end_i (rx_end),
    .tx_avail_o (tx_avail), .tx_cnt_o (tx_cnt), .tx_data_o (tx_data),
    .tx_next_i (tx_next), .tx_done_i (tx_done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // driver: IN bytes written by the cpu are the expected engine stream
  task automatic cpu_wr(input logic dir, input int addr, input logic [7:0] d, input bit push);
    cpu_dir = dir; cpu_addr = AW'(addr); cpu_wdata = d; cpu_we = 1'b1;
    step();
    cpu_we = 1'b0;
    if (push) tx_q.push_back(d);
  endtask

  task automatic cnt_wr(input logic dir, input int v);
    cpu_dir = dir; cnt_wdata = CW'(v); cnt_we = 1'b1;
    step();
    cnt_we = 1'b0;
  endtask

  task automatic tx_pull(input int n);
    for (int i = 0; i < n; i++) begin
      tx_next = 1'b1;
      step();
    end
    tx_next = 1'b0;
  endtask

  task automatic tx_fin();
    tx_done = 1'b1; step(); tx_done = 1'b0;
  endtask

  task automatic rx_go();
    rx_start = 1'b1; step(); rx_start = 1'b0;
  endtask

  task automatic rx_byte(input logic [7:0] d);
    rx_valid = 1'b1; rx_data = d; step(); rx_valid = 1'b0;
  endtask

  task automatic rx_fin(input logic clr_out);
    rx_end = 1'b1; irq_clr = {clr_out, 1'b0}; step(); rx_end = 1'b0; irq_clr = '0;
  endtask

  task automatic cpu_rd_exp(input int addr, input logic [7:0] e);
    out_q.push_back(e);
    cpu_dir = 1'b1; cpu_addr = AW'(addr); rd_chk = 1'b1;
    step();
    rd_chk = 1'b0;
  endtask

  task automatic peek(input logic dir, input int addr);
    cpu_dir = dir; cpu_addr = AW'(addr); #1;
  endtask

  // monitor: compares streamed bytes against the scoreboard queues
  always @(negedge clk) begin
    if (tx_next && tx_avail && !tx_skip) begin
      if (tx_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R6: actual byte %0h expected none", tx_data);
      end else chk("R6 tx byte", 32'(tx_data), 32'(tx_q.pop_front()));
    end
    if (rd_chk) begin
      if (out_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9: actual byte %0h expected none", cpu_rdata);
      end else chk("R9/R14 out byte", 32'(cpu_rdata), 32'(out_q.pop_front()));
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    peek(1'b0, 0);
    chk("R1 busy", 32'(cpu_busy), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 flags", 32'(irq_flag), 0);
    chk("R1 tx_avail", 32'(tx_avail), 0);
    chk("R1 in count", 32'(cpu_cnt), 0);
    peek(1'b1, 0);
    chk("R1 out count", 32'(cpu_cnt), 0);
    irq_en = 2'b11;

    // IN packet A, 5 bytes
    for (int i = 0; i < 5; i++) cpu_wr(1'b0, i, 8'hA0 + 8'(i), 1'b1);
    peek(1'b0, 2);
    chk("R2 read back", 32'(cpu_rdata), 32'hA2);
    cnt_wr(1'b0, 5);
    chk("R4 tx_avail", 32'(tx_avail), 1);
    chk("R4 tx_cnt", 32'(tx_cnt), 5);
    chk("R4 pointer moved", 32'(cpu_busy[0]), 0);

    // IN packet B, count 100 clamps to 64
    for (int i = 0; i < 64; i++) cpu_wr(1'b0, i, 8'hB0 + 8'(i), 1'b1);
    cnt_wr(1'b0, 100);
    chk("R4 both busy", 32'(cpu_busy[0]), 1);
    cpu_wr(1'b0, 0, 8'hEE, 1'b0);
    cnt_wr(1'b0, 7);
    peek(1'b0, 0);
    chk("R5 count kept", 32'(cpu_cnt), 5);
    chk("R5 busy kept", 32'(cpu_busy[0]), 1);
    chk("R3 read while busy", 32'(cpu_rdata), 0);

    // early completion is refused
    tx_pull(2);
    tx_fin();
    chk("R7 early done ignored", 32'(tx_avail), 1);
    chk("R7 count kept", 32'(tx_cnt), 5);
    chk("R12 no early flag", 32'(irq_flag[0]), 0);
    tx_pull(3);
    tx_fin();
    chk("R7 next buffer", 32'(tx_avail), 1);
    chk("R4 clamp", 32'(tx_cnt), 64);
    chk("R12 IN flag", 32'(irq_flag[0]), 1);
    chk("R13 irq", 32'(irq), 1);
    peek(1'b0, 0);
    chk("R3 cpu owns again", 32'(cpu_busy[0]), 0);
    chk("R3 busy write dropped", 32'(cpu_rdata), 32'hA0);
    irq_clr = 2'b01; step(); irq_clr = '0;
    chk("R13 flag cleared", 32'(irq_flag[0]), 0);
    chk("R13 irq low", 32'(irq), 0);

    // drain B with an extra pull, interrupt disabled
    irq_en = 2'b10;
    tx_pull(64);
    tx_skip = 1'b1; tx_pull(1); tx_skip = 1'b0;
    tx_fin();
    chk("R7 all sent", 32'(tx_avail), 0);
    chk("R12 disabled flag", 32'(irq_flag[0]), 0);
    chk("R6 stream drained", tx_q.size(), 0);

    // OUT packet 1 into buffer 0
    rx_go();
    peek(1'b1, 0);
    chk("R8 busy on start", 32'(cpu_busy[1]), 1);
    chk("R3 out read busy", 32'(cpu_rdata), 0);
    for (int i = 0; i < 4; i++) rx_byte(8'hC0 + 8'(i));
    rx_fin(1'b0);
    peek(1'b1, 0);
    chk("R10 busy cleared", 32'(cpu_busy[1]), 0);
    chk("R10 count", 32'(cpu_cnt), 4);
    chk("R12 OUT flag", 32'(irq_flag[1]), 1);
    chk("R13 irq out", 32'(irq), 1);

    // OUT packet 2 into buffer 1 while cpu reads buffer 0
    rx_go();
    peek(1'b1, 0);
    chk("R14 cpu buffer free", 32'(cpu_busy[1]), 0);
    cpu_rd_exp(1, 8'hC1);
    for (int i = 0; i < 70; i++) rx_byte(8'hD0 + 8'(i));
    rx_fin(1'b0);
    for (int i = 0; i < 4; i++) cpu_rd_exp(i, 8'hC0 + 8'(i));
    cnt_wr(1'b1, 99);
    chk("R9 saturated count", 32'(cpu_cnt), 64);
    for (int i = 0; i < 64; i++) cpu_rd_exp(i, 8'hD0 + 8'(i));
    cnt_wr(1'b1, 99);
    chk("R11 count unchanged", 32'(cpu_cnt), 4);

    // OUT packet 3 restarted mid-way, flag set wins over clear
    rx_go();
    chk("R8 busy again", 32'(cpu_busy[1]), 1);
    rx_byte(8'h11);
    rx_byte(8'h22);
    rx_go();
    rx_byte(8'h55);
    rx_fin(1'b1);
    chk("R13 set wins", 32'(irq_flag[1]), 1);
    peek(1'b1, 0);
    chk("R8 restart count", 32'(cpu_cnt), 1);
    cpu_rd_exp(0, 8'h55);
    irq_clr = 2'b10; step(); irq_clr = '0;
    chk("R13 out cleared", 32'(irq_flag[1]), 0);
    chk("R13 irq idle", 32'(irq), 0);
    chk("R9 reads consumed", out_q.size(), 0);

    finish_run();
  end
endmodule